// File: doc/BRIEF.md
# Lead-Lag Bit Clock Recovery Loop

This block recovers a symbol-rate clock from a serial NRZ data stream that arrives asynchronously to the system clock. The data is retimed through a flop chain, and every transition in either direction becomes a one-cycle edge pulse. A free-running counter serves as the digitally controlled oscillator. Its nominal period is one symbol time of `SYM_CLKS` system clocks.

At each edge pulse the counter value is compared with the half-symbol point. A count above that point means the oscillator runs early. The next oscillator period is then stretched by `STEP` clocks. A count below it means the oscillator runs late, and the next period is shortened by `STEP` clocks. Each correction lasts for a single period only. No loop filter sits between the comparison and the oscillator.

A mode input chooses where the sample strobe and the recovered bit clock sit within the counter cycle. They can sit at the counter start, which suits square-wave data sampled at its edges. They can also be offset by half a symbol, which suits pulse-shaped data sampled at symbol centres.

Top module: `bitsync_dpll`

## Requirements
- R1: While `rst_n` is low, `bit_clk`, `sample_stb`, `lead` and `lag` are 0. The oscillator count is 0 and its period is `SYM_CLKS`. Outputs stay masked until the first clock edge after release.
- R2: With no data transitions, `sample_stb` pulses once every `SYM_CLKS` clocks.
- R3: If an edge pulse sees a count greater than `SYM_CLKS/2`, `lead` is high for the following cycle. The oscillator period after the next wrap is then `SYM_CLKS+STEP`.
- R4: If an edge pulse sees a count less than `SYM_CLKS/2`, `lag` is high for the following cycle. The oscillator period after the next wrap is then `SYM_CLKS-STEP`.
- R5: If an edge pulse sees a count exactly equal to `SYM_CLKS/2`, neither flag rises and no correction is made. A data stream at exactly the symbol rate settles into this state.
- R6: A correction lasts one oscillator period. After that period the period returns to `SYM_CLKS`, unless a newer edge has set another correction.
- R7: Both rising and falling transitions of `data_in` are detected. A change sampled at clock edge k gives an edge pulse during the cycle after clock edge k+1. That pulse lasts one cycle per transition.
- R8: With `mode_mid`=0, `sample_stb` is high while the count is 0, and `bit_clk` is high while the count is below `SYM_CLKS/2`. With `mode_mid`=1, `sample_stb` is high at count `SYM_CLKS/2`, and `bit_clk` is high while the count is at or above `SYM_CLKS/2`.
- R9: An edge pulse in the same cycle as a counter wrap does not change the period being loaded at that wrap. Its correction goes to the period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Serial NRZ data, asynchronous |
| mode_mid | input | 1 | 0: edge-aligned outputs, 1: midpoint-aligned outputs |
| bit_clk | output | 1 | Recovered symbol clock |
| sample_stb | output | 1 | One-cycle sample strobe per oscillator period |
| lead | output | 1 | Pulse: last comparison found the oscillator early |
| lag | output | 1 | Pulse: last comparison found the oscillator late |

## Verification
Steady data with no transitions shows the free-running period on its own. Alternating data at exactly the symbol rate shows the loop settling to the lock point, where corrections stop. Data at one clock slower and one clock faster than the symbol rate forces repeated stretch and shrink corrections, so lead and lag are checked apart. Pseudo-random data with jittered bit lengths, and toggling on every clock, make edges land on wraps and on the half-symbol point. Both values of the mode input are applied with each pattern.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
   typedef enum logic [1:0] {
      ADJ_NONE = 2'd0,
      ADJ_SLOW = 2'd1,
      ADJ_FAST = 2'd2
   } adj_e;
endpackage

// File: rtl/bsync_edge.sv
module bsync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_p
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign edge_p = chain[STAGES-1] ^ last_q;

   // R7: a pulse reflects a change that travelled down the chain
   assert_edge_from_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |=> (last_q != $past(last_q)));
endmodule

// File: rtl/bsync_phase.sv
module bsync_phase
   import bsync_pkg::*;
#(
   parameter int SYM_CLKS = 16,
   parameter int CW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_p,
   input  logic          wrap,
   input  logic [CW-1:0] cnt,
   output adj_e          pend,
   output logic          lead,
   output logic          lag
);
   localparam logic [CW-1:0] HALF = CW'(SYM_CLKS / 2);

   logic early, late;
   adj_e verdict;

   assign early = cnt > HALF;
   assign late  = cnt < HALF;

   always_comb begin
      if (early)     verdict = ADJ_SLOW;
      else if (late) verdict = ADJ_FAST;
      else           verdict = ADJ_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= ADJ_NONE;
         lead <= 1'b0;
         lag  <= 1'b0;
      end else begin
         if (edge_p)    pend <= verdict;
         else if (wrap) pend <= ADJ_NONE;
         lead <= edge_p & early;
         lag  <= edge_p & late;
      end
   end

   assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead, lag}));
   assert_lead_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lead |-> $past(edge_p));
   assert_lag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lag |-> $past(edge_p));
   assert_pend_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !edge_p) |=> pend == ADJ_NONE);
endmodule

// File: rtl/bsync_nco.sv
module bsync_nco
   import bsync_pkg::*;
#(
   parameter int SYM_CLKS = 16,
   parameter int STEP     = 1,
   parameter int CW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  adj_e          pend,
   output logic          wrap,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] P_NOM  = CW'(SYM_CLKS);
   localparam logic [CW-1:0] P_LONG = CW'(SYM_CLKS + STEP);
   localparam logic [CW-1:0] P_SHRT = CW'(SYM_CLKS - STEP);

   logic [CW-1:0] per_q;
   logic [CW-1:0] per_next;

   assign wrap = (cnt == per_q - CW'(1));

   always_comb begin
      unique case (pend)
         ADJ_SLOW: per_next = P_LONG;
         ADJ_FAST: per_next = P_SHRT;
         default:  per_next = P_NOM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         per_q <= P_NOM;
      end else if (wrap) begin
         cnt   <= '0;
         per_q <= per_next;
      end else begin
         cnt   <= cnt + CW'(1);
      end
   end

   assert_cnt_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < per_q);
   assert_period_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (per_q == P_NOM || per_q == P_LONG || per_q == P_SHRT));
   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == '0);
endmodule

// File: rtl/bsync_outphase.sv
module bsync_outphase #(
   parameter int SYM_CLKS = 16,
   parameter int CW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          mode_mid,
   output logic          bit_clk,
   output logic          strobe
);
   localparam logic [CW-1:0] HALF = CW'(SYM_CLKS / 2);

   logic armed;
   logic first_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign first_half = cnt < HALF;
   assign bit_clk = armed & (mode_mid ? ~first_half : first_half);
   assign strobe  = armed & (cnt == (mode_mid ? HALF : '0));

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
   assert_strobe_in_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> bit_clk);
endmodule

// File: rtl/bitsync_dpll.sv
module bitsync_dpll
   import bsync_pkg::*;
#(
   parameter int SYM_CLKS    = 16,
   parameter int STEP        = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic data_in,
   input  logic mode_mid,
   output logic bit_clk,
   output logic sample_stb,
   output logic lead,
   output logic lag
);
   localparam int CW = $clog2(SYM_CLKS + STEP + 1);

   initial begin
      assert (SYM_CLKS >= 4) else $error("SYM_CLKS must be at least 4");
      assert (STEP >= 1 && STEP < SYM_CLKS / 2) else $error("STEP out of range");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic          edge_p;
   logic          wrap;
   logic [CW-1:0] cnt;
   adj_e          pend;

   bsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(data_in), .edge_p(edge_p)
   );

   bsync_phase #(.SYM_CLKS(SYM_CLKS), .CW(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .edge_p(edge_p), .wrap(wrap), .cnt(cnt),
      .pend(pend), .lead(lead), .lag(lag)
   );

   bsync_nco #(.SYM_CLKS(SYM_CLKS), .STEP(STEP), .CW(CW)) u_nco (
      .clk(clk), .rst_n(rst_n), .pend(pend), .wrap(wrap), .cnt(cnt)
   );

   bsync_outphase #(.SYM_CLKS(SYM_CLKS), .CW(CW)) u_out (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .mode_mid(mode_mid),
      .bit_clk(bit_clk), .strobe(sample_stb)
   );

   // R9: an edge on a wrap leaves a pending correction for the next period
   assert_edge_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && wrap && cnt != CW'(SYM_CLKS / 2)) |=> pend != ADJ_NONE);
endmodule

// File: tb/bitsync_dpll_test.sv
module bitsync_dpll_test;
   localparam int TB   = 16;
   localparam int DLT  = 1;
   localparam int NS   = 2;
   localparam int H    = TB / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic data_in = 1'b0;
   logic mode_mid = 1'b0;
   logic bit_clk, sample_stb, lead, lag;

   always #10 clk = ~clk;

   bitsync_dpll #(.SYM_CLKS(TB), .STEP(DLT), .SYNC_STAGES(NS)) uut (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .mode_mid(mode_mid),
      .bit_clk(bit_clk), .sample_stb(sample_stb), .lead(lead), .lag(lag)
   );

   int checks = 0;
   int fails  = 0;
   int cycle  = 0;
   bit done   = 0;

   // behavioural model state
   int  m_sync[NS];
   int  m_prev = 0, m_cnt = 0, m_per = TB, m_pend = 0, m_armed = 0;
   int  m_lead = 0, m_lag = 0;

   // window statistics
   int  n_lead = 0, n_lag = 0;
   int  last_stb = -1, stb_gap = -1;

   initial for (int i = 0; i < NS; i++) m_sync[i] = 0;

   always @(posedge clk) begin
      cycle <= cycle + 1;
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) m_sync[i] = 0;
         m_prev = 0; m_cnt = 0; m_per = TB; m_pend = 0; m_armed = 0;
         m_lead = 0; m_lag = 0;
      end else begin
         int e, c, w, np;
         e = m_sync[NS-1] ^ m_prev;
         c = m_cnt;
         w = (c == m_per - 1);
         np = (m_pend == 1) ? TB + DLT : (m_pend == 2) ? TB - DLT : TB;
         m_lead = e && (c > H);
         m_lag  = e && (c < H);
         if (e) m_pend = (c > H) ? 1 : (c < H) ? 2 : 0;
         else if (w) m_pend = 0;
         if (w) begin m_cnt = 0; m_per = np; end
         else m_cnt = c + 1;
         m_prev = m_sync[NS-1];
         for (int i = NS-1; i > 0; i--) m_sync[i] = m_sync[i-1];
         m_sync[0] = data_in;
         m_armed = 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycle, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_bc, e_st;
         e_bc = m_armed && (mode_mid ? (m_cnt >= H) : (m_cnt < H));
         e_st = m_armed && (m_cnt == (mode_mid ? H : 0));
         check("R8 R1 bit_clk", bit_clk, e_bc);
         check("R8 R2 R6 R9 sample_stb", sample_stb, e_st);
         check("R3 R7 R5 lead", lead, m_lead);
         check("R4 R7 R5 lag", lag, m_lag);
         n_lead += lead;
         n_lag  += lag;
         if (sample_stb) begin
            if (last_stb >= 0) stb_gap = cycle - last_stb;
            last_stb = cycle;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic bits(input int count, input int len);
      for (int i = 0; i < count; i++) begin
         data_in = ~data_in;
         step(len);
      end
   endtask

   // watchdog
   initial begin
      #3000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      step(3);
      // R1: reset state
      check("R1 bit_clk in reset", bit_clk, 0);
      check("R1 sample_stb in reset", sample_stb, 0);
      check("R1 lead in reset", lead, 0);
      check("R1 lag in reset", lag, 0);
      rst_n = 1'b1;

      // R2: free run, no edges
      step(70);
      check("R2 free-run strobe gap", stb_gap, TB);

      // R5: lock at exact symbol rate
      bits(30, TB);
      n_lead = 0; n_lag = 0;
      bits(8, TB);
      check("R5 no lead once locked", n_lead, 0);
      check("R5 no lag once locked", n_lag, 0);
      mode_mid = 1'b1;
      bits(8, TB);
      check("R8 midpoint gap while locked", stb_gap, TB);

      // R3: slow data forces leads
      n_lead = 0; n_lag = 0;
      bits(20, TB + 1);
      check("R3 leads seen on slow data", (n_lead > 0) ? 1 : 0, 1);
      mode_mid = 1'b0;

      // R4: fast data forces lags
      n_lead = 0; n_lag = 0;
      bits(20, TB - 1);
      check("R4 lags seen on fast data", (n_lag > 0) ? 1 : 0, 1);

      // jittered pseudo-random data, both modes (R9 edges hit wraps)
      for (int i = 0; i < 150; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[0]) data_in = ~data_in;
         if (i == 75) mode_mid = ~mode_mid;
         step(TB - 2 + int'(lfsr[3:2]));
      end

      // R7: toggle every cycle
      bits(40, 1);
      step(3 * TB);
      check("R2 gap after toggle burst", stb_gap, TB);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule